// File: doc/BRIEF.md
# Micro-op Dispatch Port Scheduler

This block is the dispatch stage of an out-of-order core. It keeps a small window of waiting micro-ops in age order, and in each cycle it picks which of them leave through four issue ports. Port 0 feeds a fast integer ALU. Port 1 is shared by a second fast integer ALU, a non-pipelined slow integer ALU and an FP/MMX execute cluster of seven sub-pipelines. Port 2 feeds the load unit and port 3 feeds the store unit. Both fast-ALU ports are double-pumped, so each of them takes up to two simple integer ops per clock. A single cycle can therefore dispatch at most six micro-ops.

Every micro-op carries a class code. The scheduler sends each class only to a unit that can execute it. It tracks the non-pipelined units (slow ALU and FP divider) with busy down-counters. A micro-op whose unit is occupied waits, and younger micro-ops of other classes go around it. The outputs are one grant vector per port, indexed by window entry (bit 0 is the oldest entry), plus a unit select for port 1 and a one-hot FP/MMX sub-pipeline select. Granted entries leave the window at the next clock edge. The survivors move down, keeping their order, and one new micro-op per cycle can be appended as the youngest.

Top module: `uop_port_sched`

## Requirements
- R1: After a synchronous active-high reset the window is empty: all four grant vectors are zero, `p1_sel` is 0, `fp_sel` is 0 and `in_ready` is 1.
- R2: Port 0 grants up to two simple integer ops (class 0), choosing the oldest ones in the window. No other class ever appears on `gnt_p0`.
- R3: Port 1 grants either up to two simple integer ops or exactly one slow/FP op, and the oldest port-1 candidate decides which. The simple ops it may take are the third and fourth oldest simple ops. `p1_sel` encodes the choice: 0 none, 1 fast pair, 2 slow ALU, 3 FP/MMX cluster.
- R4: Port 2 grants the oldest load (class 9) and port 3 grants the oldest store (class 10). The ports never grant the same entry, and no more than six entries are granted in one cycle.
- R5: A shift/complex integer op (class 1) is dispatched only on port 1 with `p1_sel`=2.
- R6: FP/MMX classes go on port 1 with `p1_sel`=3. `fp_sel` is one-hot: bit 0 FP add (class 2), bit 1 FP multiply (3), bit 2 FP divide (4), bit 3 FP misc (5), bit 4 MMX shift (6), bit 5 MMX ALU (7), bit 6 MMX misc (8).
- R7: After the slow ALU is granted it cannot be granted again for LAT_SLOW cycles, counting the grant cycle. The same holds for the FP divider with LAT_DIV. It becomes grantable in exactly the next cycle after that.
- R8: A micro-op that is blocked by a busy unit does not stop younger micro-ops of other classes from being granted in the same cycle.
- R9: Granted entries are removed at the next edge and the survivors keep their age order from entry 0 upward. A new op is appended as the youngest when `in_valid` is high and `in_ready` is 1. `in_ready` is 0 when all DEPTH entries are valid, and an op offered then is dropped.
- R10: While `stall` is high no grants are issued and the window contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Suppresses all grants this cycle |
| in_valid | input | 1 | New micro-op offered to the window |
| in_cls | input | 4 | Class code of the offered micro-op (0..10) |
| in_ready | output | 1 | Window has a free entry |
| gnt_p0 | output | DEPTH | Entries granted on port 0 (fast ALU 0) |
| gnt_p1 | output | DEPTH | Entries granted on port 1 |
| gnt_p2 | output | DEPTH | Entry granted on port 2 (load) |
| gnt_p3 | output | DEPTH | Entry granted on port 3 (store) |
| p1_sel | output | 2 | Port 1 unit select: 0 none, 1 fast, 2 slow, 3 FP/MMX |
| fp_sel | output | 7 | One-hot FP/MMX sub-pipeline select |

## Verification
Two things can happen in the same cycle: port 1 chooses between a pair of simple ops and one slow/FP op, and a busy unit forces younger ops to be granted around a blocked older one. The bench fills the window while `stall` is high and then releases it. This sets up a shift behind three simple ops and an FP multiply ahead of two simple ops. It also sets up an FP divide followed by a second divide, a shift and an MMX op, so that one divider occupation overlaps with a slow-ALU occupation. The bench checks each cycle's grant vectors and selects against entry indices worked out by hand, including the exact cycle in which each busy unit accepts again.

// File: rtl/dsched_pkg.sv
package dsched_pkg;

    typedef enum logic [3:0] {
        UC_INT   = 4'd0,
        UC_SHIFT = 4'd1,
        UC_FADD  = 4'd2,
        UC_FMUL  = 4'd3,
        UC_FDIV  = 4'd4,
        UC_FMISC = 4'd5,
        UC_XSHF  = 4'd6,
        UC_XALU  = 4'd7,
        UC_XMISC = 4'd8,
        UC_LOAD  = 4'd9,
        UC_STORE = 4'd10
    } uop_cls_e;

    typedef enum logic [1:0] {
        P1_IDLE = 2'd0,
        P1_FAST = 2'd1,
        P1_SLOW = 2'd2,
        P1_FPX  = 2'd3
    } p1_sel_e;

    localparam int FPX_PIPES = 7;

    typedef struct packed {
        logic     vld;
        uop_cls_e cls;
    } win_ent_t;

    function automatic logic is_fpx(uop_cls_e c);
        return (c >= UC_FADD) && (c <= UC_XMISC);
    endfunction

    function automatic logic [FPX_PIPES-1:0] fpx_onehot(uop_cls_e c);
        logic [FPX_PIPES-1:0] r;
        r = '0;
        if (is_fpx(c)) r[c - UC_FADD] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/dsched_busy.sv
module dsched_busy
    import dsched_pkg::*;
#(
    parameter int LAT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic busy
);
    localparam int CW = (LAT < 2) ? 1 : $clog2(LAT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load)
            st_d.cnt = CW'(LAT - 1);
        else if (st_q.cnt != '0)
            st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign busy = (st_q.cnt != '0);

    // R7: the picker must never load an occupied unit
    assert_no_grant_busy_R7: assert property (@(posedge clk) disable iff (rst)
        load |-> !busy);

    // R7: an idle unit with no grant stays idle
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!busy && !load) |=> !busy);

endmodule

// File: rtl/dsched_window.sv
module dsched_window
    import dsched_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  uop_cls_e               in_cls,
    input  logic [DEPTH-1:0]       retire,
    output logic [DEPTH-1:0]       vld_o,
    output uop_cls_e [DEPTH-1:0]   cls_o,
    output logic                   in_ready
);
    localparam int IW = $clog2(DEPTH);

    typedef struct packed {
        win_ent_t [DEPTH-1:0] ent;
    } st_t;

    st_t         st_d, st_q;
    logic [IW:0] pos;

    always_comb begin
        st_d = '0;
        pos  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (st_q.ent[i].vld && !retire[i]) begin
                st_d.ent[pos[IW-1:0]] = st_q.ent[i];
                pos = pos + 1'b1;
            end
        end
        if (in_valid && in_ready && (pos < DEPTH)) begin
            st_d.ent[pos[IW-1:0]].vld = 1'b1;
            st_d.ent[pos[IW-1:0]].cls = in_cls;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            vld_o[i] = st_q.ent[i].vld;
            cls_o[i] = st_q.ent[i].cls;
        end
    end

    assign in_ready = !st_q.ent[DEPTH-1].vld;

    // R9: only occupied entries may be retired
    assert_retire_valid_R9: assert property (@(posedge clk) disable iff (rst)
        (retire & ~vld_o) == '0);

    // R9: an offer to a full window with nothing leaving changes nothing
    assert_full_drop_R9: assert property (@(posedge clk) disable iff (rst)
        (!in_ready && retire == '0) |=> $stable(vld_o));

endmodule

// File: rtl/dsched_pick.sv
module dsched_pick
    import dsched_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   stall,
    input  logic [DEPTH-1:0]       vld,
    input  uop_cls_e [DEPTH-1:0]   cls,
    input  logic                   slow_busy,
    input  logic                   div_busy,
    output logic [DEPTH-1:0]       g0,
    output logic [DEPTH-1:0]       g1,
    output logic [DEPTH-1:0]       g2,
    output logic [DEPTH-1:0]       g3,
    output p1_sel_e                p1s,
    output logic [FPX_PIPES-1:0]   fps,
    output logic                   ld_slow,
    output logic                   ld_div
);
    localparam int IW = $clog2(DEPTH);

    logic [DEPTH-1:0] p1_simple;
    logic [DEPTH-1:0] int_mask;
    logic [2:0]       sc;
    logic             found, got_ld, got_st;
    logic [IW-1:0]    first;

    always_comb begin
        g0 = '0; g1 = '0; g2 = '0; g3 = '0;
        p1s = P1_IDLE; fps = '0; ld_slow = 1'b0; ld_div = 1'b0;
        p1_simple = '0; int_mask = '0; sc = '0;
        found = 1'b0; got_ld = 1'b0; got_st = 1'b0; first = '0;
        for (int i = 0; i < DEPTH; i++)
            int_mask[i] = vld[i] && (cls[i] == UC_INT);
        if (!stall) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (int_mask[i]) begin
                    if (sc < 3'd2)      g0[i] = 1'b1;
                    else if (sc < 3'd4) p1_simple[i] = 1'b1;
                    if (sc < 3'd4)      sc = sc + 1'b1;
                end
                if (vld[i] && cls[i] == UC_LOAD && !got_ld) begin
                    g2[i] = 1'b1; got_ld = 1'b1;
                end
                if (vld[i] && cls[i] == UC_STORE && !got_st) begin
                    g3[i] = 1'b1; got_st = 1'b1;
                end
            end
            for (int i = 0; i < DEPTH; i++) begin
                if (!found && (p1_simple[i] ||
                    (vld[i] && cls[i] == UC_SHIFT && !slow_busy) ||
                    (vld[i] && is_fpx(cls[i]) && !(cls[i] == UC_FDIV && div_busy)))) begin
                    found = 1'b1;
                    first = IW'(i);
                end
            end
            if (found) begin
                if (p1_simple[first]) begin
                    g1  = p1_simple;
                    p1s = P1_FAST;
                end else begin
                    g1[first] = 1'b1;
                    if (cls[first] == UC_SHIFT) begin
                        p1s     = P1_SLOW;
                        ld_slow = 1'b1;
                    end else begin
                        p1s    = P1_FPX;
                        fps    = fpx_onehot(cls[first]);
                        ld_div = (cls[first] == UC_FDIV);
                    end
                end
            end
        end
    end

    assert_port0_cap_R2: assert property (@(posedge clk) disable iff (rst)
        ($countones(g0) <= 2) && ((g0 & ~int_mask) == '0));

    assert_p1_mode_R3: assert property (@(posedge clk) disable iff (rst)
        ((g1 == '0) == (p1s == P1_IDLE)) && ((p1s != P1_FAST) -> ($countones(g1) <= 1)));

    assert_ports_disjoint_R4: assert property (@(posedge clk) disable iff (rst)
        ((g0 & g1) | (g0 & g2) | (g0 & g3) | (g1 & g2) | (g1 & g3) | (g2 & g3)) == '0);

    assert_six_max_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(g2) && $onehot0(g3) &&
        (($countones(g0) + $countones(g1) + $countones(g2) + $countones(g3)) <= 6));

    assert_shift_slow_R5: assert property (@(posedge clk) disable iff (rst)
        ld_slow |-> (p1s == P1_SLOW) && (fps == '0));

    assert_fp_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fps) && ((fps != '0) == (p1s == P1_FPX)));

    assert_stall_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        stall |-> ((g0 | g1 | g2 | g3) == '0) && !ld_slow && !ld_div);

endmodule

// File: rtl/uop_port_sched.sv
module uop_port_sched
    import dsched_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int LAT_SLOW = 4,
    parameter int LAT_DIV  = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stall,
    input  logic             in_valid,
    input  logic [3:0]       in_cls,
    output logic             in_ready,
    output logic [DEPTH-1:0] gnt_p0,
    output logic [DEPTH-1:0] gnt_p1,
    output logic [DEPTH-1:0] gnt_p2,
    output logic [DEPTH-1:0] gnt_p3,
    output logic [1:0]       p1_sel,
    output logic [6:0]       fp_sel
);
    logic [DEPTH-1:0]     win_vld;
    uop_cls_e [DEPTH-1:0] win_cls;
    logic                 slow_busy, div_busy, ld_slow, ld_div;
    p1_sel_e              p1s;

    dsched_window #(.DEPTH(DEPTH)) u_window (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_cls   (uop_cls_e'(in_cls)),
        .retire   (gnt_p0 | gnt_p1 | gnt_p2 | gnt_p3),
        .vld_o    (win_vld),
        .cls_o    (win_cls),
        .in_ready (in_ready)
    );

    dsched_pick #(.DEPTH(DEPTH)) u_pick (
        .clk       (clk),
        .rst       (rst),
        .stall     (stall),
        .vld       (win_vld),
        .cls       (win_cls),
        .slow_busy (slow_busy),
        .div_busy  (div_busy),
        .g0        (gnt_p0),
        .g1        (gnt_p1),
        .g2        (gnt_p2),
        .g3        (gnt_p3),
        .p1s       (p1s),
        .fps       (fp_sel),
        .ld_slow   (ld_slow),
        .ld_div    (ld_div)
    );

    dsched_busy #(.LAT(LAT_SLOW)) u_slow_busy (
        .clk  (clk),
        .rst  (rst),
        .load (ld_slow),
        .busy (slow_busy)
    );

    dsched_busy #(.LAT(LAT_DIV)) u_div_busy (
        .clk  (clk),
        .rst  (rst),
        .load (ld_div),
        .busy (div_busy)
    );

    assign p1_sel = p1s;

endmodule

// File: tb/test_uop_port_sched.sv
module test_uop_port_sched;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int LS         = 4;
    localparam int LD         = 6;

    localparam logic [3:0] C_INT = 0, C_SHF = 1, C_FADD = 2, C_FMUL = 3, C_FDIV = 4,
                           C_FMISC = 5, C_XSHF = 6, C_XALU = 7, C_XMISC = 8,
                           C_LD = 9, C_ST = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             stall = 1'b1;
    logic             in_valid = 1'b0;
    logic [3:0]       in_cls = '0;
    logic             in_ready;
    logic [DEPTH-1:0] gnt_p0, gnt_p1, gnt_p2, gnt_p3;
    logic [1:0]       p1_sel;
    logic [6:0]       fp_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    uop_port_sched #(.DEPTH(DEPTH), .LAT_SLOW(LS), .LAT_DIV(LD)) i_uop_port_sched (
        .clk(clk), .rst(rst), .stall(stall), .in_valid(in_valid), .in_cls(in_cls),
        .in_ready(in_ready), .gnt_p0(gnt_p0), .gnt_p1(gnt_p1), .gnt_p2(gnt_p2),
        .gnt_p3(gnt_p3), .p1_sel(p1_sel), .fp_sel(fp_sel)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_all(input string req, input logic [7:0] e0, input logic [7:0] e1,
                           input logic [7:0] e2, input logic [7:0] e3,
                           input logic [1:0] esel, input logic [6:0] efp);
        chk({req, " p0"}, 32'(gnt_p0), 32'(e0));
        chk({req, " p1"}, 32'(gnt_p1), 32'(e1));
        chk({req, " p2"}, 32'(gnt_p2), 32'(e2));
        chk({req, " p3"}, 32'(gnt_p3), 32'(e3));
        chk({req, " p1_sel"}, 32'(p1_sel), 32'(esel));
        chk({req, " fp_sel"}, 32'(fp_sel), 32'(efp));
    endtask

    task automatic enq(input logic [3:0] c);
        @(negedge clk);
        stall    = 1'b1;
        in_valid = 1'b1;
        in_cls   = c;
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic release_win();
        @(negedge clk);
        stall = 1'b0;
        #1;
    endtask

    task automatic cyc();
        @(negedge clk);
        #1;
    endtask

    task automatic settle();
        @(negedge clk);
        stall = 1'b1;
        repeat (LD + 2) @(negedge clk);
    endtask

    task automatic t_reset();
        #1;
        chk_all("R1 reset", 8'h00, 8'h00, 8'h00, 8'h00, 2'd0, 7'h00);
        chk("R1 in_ready", 32'(in_ready), 32'd1);
    endtask

    task automatic t_mixed_six();
        enq(C_INT); enq(C_INT); enq(C_INT); enq(C_INT);
        enq(C_INT); enq(C_LD); enq(C_ST); enq(C_LD);
        cyc();
        chk_all("R10 stalled", 8'h00, 8'h00, 8'h00, 8'h00, 2'd0, 7'h00);
        release_win();
        chk_all("R2 R4 six-wide", 8'h03, 8'h0C, 8'h20, 8'h40, 2'd1, 7'h00);
        cyc();
        chk_all("R9 compacted", 8'h01, 8'h00, 8'h02, 8'h00, 2'd0, 7'h00);
        cyc();
        chk_all("R9 drained", 8'h00, 8'h00, 8'h00, 8'h00, 2'd0, 7'h00);
        settle();
    endtask

    task automatic t_fp_before_pair();
        enq(C_INT); enq(C_INT); enq(C_FMUL); enq(C_INT); enq(C_INT);
        release_win();
        chk_all("R3 older fp wins port1", 8'h03, 8'h04, 8'h00, 8'h00, 2'd3, 7'h02);
        cyc();
        chk_all("R2 survivors", 8'h03, 8'h00, 8'h00, 8'h00, 2'd0, 7'h00);
        settle();
    endtask

    task automatic t_shift_after_simple();
        enq(C_INT); enq(C_INT); enq(C_INT); enq(C_SHF);
        release_win();
        chk_all("R3 older simple wins port1", 8'h03, 8'h04, 8'h00, 8'h00, 2'd1, 7'h00);
        cyc();
        chk_all("R5 shift on slow alu", 8'h00, 8'h01, 8'h00, 8'h00, 2'd2, 7'h00);
        settle();
    endtask

    task automatic t_slow_busy();
        enq(C_SHF); enq(C_SHF); enq(C_INT);
        release_win();
        chk_all("R5 first shift", 8'h04, 8'h01, 8'h00, 8'h00, 2'd2, 7'h00);
        for (int k = 1; k < LS; k++) begin
            cyc();
            chk_all("R7 slow alu busy", 8'h00, 8'h00, 8'h00, 8'h00, 2'd0, 7'h00);
        end
        cyc();
        chk_all("R7 slow alu free again", 8'h00, 8'h01, 8'h00, 8'h00, 2'd2, 7'h00);
        settle();
    endtask

    task automatic t_div_bypass();
        enq(C_FDIV); enq(C_FDIV); enq(C_SHF); enq(C_XALU);
        release_win();
        chk_all("R6 fp divide", 8'h00, 8'h01, 8'h00, 8'h00, 2'd3, 7'h04);
        cyc();
        chk_all("R8 shift passes blocked divide", 8'h00, 8'h02, 8'h00, 8'h00, 2'd2, 7'h00);
        cyc();
        chk_all("R8 mmx passes blocked divide", 8'h00, 8'h02, 8'h00, 8'h00, 2'd3, 7'h20);
        for (int k = 3; k < LD; k++) begin
            cyc();
            chk_all("R7 divider busy", 8'h00, 8'h00, 8'h00, 8'h00, 2'd0, 7'h00);
        end
        cyc();
        chk_all("R7 divider free again", 8'h00, 8'h01, 8'h00, 8'h00, 2'd3, 7'h04);
        settle();
    endtask

    task automatic t_fp_map();
        logic [3:0] cl [6];
        logic [6:0] ex [6];
        cl = '{C_FADD, C_FMUL, C_FMISC, C_XSHF, C_XALU, C_XMISC};
        ex = '{7'h01, 7'h02, 7'h08, 7'h10, 7'h20, 7'h40};
        for (int j = 0; j < 6; j++) enq(cl[j]);
        release_win();
        for (int j = 0; j < 6; j++) begin
            if (j > 0) cyc();
            chk_all("R6 sub-pipe select", 8'h00, 8'h01, 8'h00, 8'h00, 2'd3, ex[j]);
        end
        settle();
    endtask

    task automatic t_full();
        for (int j = 0; j < DEPTH; j++) enq(C_LD);
        #1;
        chk("R9 full in_ready", 32'(in_ready), 32'd0);
        enq(C_ST);
        cyc();
        chk_all("R10 full stalled", 8'h00, 8'h00, 8'h00, 8'h00, 2'd0, 7'h00);
        release_win();
        for (int j = 0; j < DEPTH; j++) begin
            if (j > 0) cyc();
            chk_all("R4 oldest load", 8'h00, 8'h00, 8'h01, 8'h00, 2'd0, 7'h00);
        end
        cyc();
        chk_all("R9 dropped store absent", 8'h00, 8'h00, 8'h00, 8'h00, 2'd0, 7'h00);
        chk("R9 ready after drain", 32'(in_ready), 32'd1);
        settle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_mixed_six();
        t_fp_before_pair();
        t_shift_after_simple();
        t_slow_busy();
        t_div_bypass();
        t_fp_map();
        t_full();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule